// File: doc/BRIEF.md
# Indirect Configuration Table Access Engine

This block lets a host register port reach two configuration tables that have no direct addresses: a scheme table of 32 entries of 23 words each, and a port partition table of 64 entries of two words each. The host stages an entry's words in a shared window of registers, then writes a single command word. That word names the table, the entry index, the direction of the copy and which words to move. The engine copies between the window and the addressed entry after a fixed number of cycles and then drops its GO flag.

Software polls the command word until GO reads 0 and then checks the error flag. A read command leaves the entry's words in the window for the host to collect. A write command stores the window contents as they stood when the command was accepted. The host addresses 32-bit words. The window starts at word 0x40 (byte 0x100) and the command word is at word 0x7F (byte 0x1FC).

Top module: `cfg_table_access`

## Requirements
- R1: After reset every table entry, every window word and the command word read 0.
- R2: A host write to the command word with bit 31 (GO) set while idle starts an operation. GO reads 1 for exactly LAT cycles and then reads 0.
- R3: With select bits 25:24 = 00, the scheme entry whose index is in bits 23:16 is copied. Bit 30 = 1 copies the entry into window words 0..22. Bit 30 = 0 copies the window into the entry.
- R4: On a scheme write, window word 16 (byte 0x140, the packet counter) is stored only when bit 15 is set. Otherwise the entry keeps its old counter value.
- R5: With select = 10, the port entry whose index is in bits 7:0 is copied. Bit 15 selects the scheme-partition word (window word 0). Bit 14 selects the plan-partition word (window word 1). Words that are not selected are left unchanged in both the entry and the window.
- R6: Bit 29 reads 1 after a command that has select 01 or 11, a scheme index of 32 or more, or a port index of 64 or more. Such a command changes no table and no window word. A command that completes without error clears bit 29.
- R7: A write to the command word while GO reads 1 is ignored.
- R8: Window words written while GO reads 1 do not affect the running command. They remain in the window for the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | 7 | Host word address (0x40.. window, 0x7F command) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_waddr (combinational) |

## Verification
GO appears at the clock edge that takes the command write. The copy into the table or the window lands on the LAT-th edge after that, and GO falls at the same edge. The bench drives and samples on falling edges. It polls GO and counts the falling edges at which GO reads 1, expecting exactly LAT of them. Window words and the error bit are compared only after GO has been seen low, against a bench model of both tables. For R7 and R8, the extra write falls on the falling edge right after the command, while GO must still be high.

// File: rtl/cfg_table_access.sv
module cfg_table_access #(
  parameter int SCH_N    = 32,
  parameter int PRT_N    = 64,
  parameter int WIN_W    = 23,
  parameter int CNT_SLOT = 16,
  parameter int LAT      = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [6:0]  host_waddr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int SW  = $clog2(SCH_N);
  localparam int PW  = $clog2(PRT_N);
  localparam int WIW = $clog2(WIN_W);
  localparam int CW  = $clog2(LAT + 1);
  localparam logic [6:0] CMD_ADDR = 7'h7F;
  localparam logic [6:0] WIN_BASE = 7'h40;

  logic [31:0] win    [WIN_W];
  logic [31:0] shadow [WIN_W];
  logic [31:0] sch    [SCH_N][WIN_W];
  logic [31:0] prt    [PRT_N][2];
  logic [30:0] cmd_q;
  logic        busy, err_q;
  logic [CW-1:0] cnt;

  wire [6:0]    widx   = host_waddr - WIN_BASE;
  wire          win_hit = (host_waddr >= WIN_BASE) && (32'(widx) < WIN_W);
  wire          ar_wr  = host_wr && (host_waddr == CMD_ADDR);
  wire          start  = ar_wr && !busy && host_wdata[31];
  wire          done   = busy && (cnt == '0);
  wire [1:0]    sel    = cmd_q[25:24];
  wire          rd_dir = cmd_q[30];
  wire [SW-1:0] si     = cmd_q[16 +: SW];
  wire [PW-1:0] pi     = cmd_q[0 +: PW];
  wire          cmd_bad = (sel == 2'b00) ? (32'(cmd_q[23:16]) >= SCH_N) :
                          (sel == 2'b10) ? (32'(cmd_q[7:0]) >= PRT_N) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      err_q <= 1'b0;
      cmd_q <= '0;
      cnt   <= '0;
      for (int i = 0; i < WIN_W; i++) begin
        win[i]    <= '0;
        shadow[i] <= '0;
      end
      for (int e = 0; e < SCH_N; e++)
        for (int i = 0; i < WIN_W; i++) sch[e][i] <= '0;
      for (int e = 0; e < PRT_N; e++) begin
        prt[e][0] <= '0;
        prt[e][1] <= '0;
      end
    end else begin
      if (host_wr && win_hit) win[widx[WIW-1:0]] <= host_wdata;
      if (start) begin
        busy  <= 1'b1;
        cmd_q <= host_wdata[30:0];
        cnt   <= CW'(LAT - 1);
        for (int i = 0; i < WIN_W; i++) shadow[i] <= win[i];
      end else if (busy && !done) begin
        cnt <= cnt - 1'b1;
      end
      if (done) begin
        busy  <= 1'b0;
        err_q <= cmd_bad;
        if (!cmd_bad && sel == 2'b00) begin
          for (int i = 0; i < WIN_W; i++) begin
            if (rd_dir) win[i] <= sch[si][i];
            else if (i != CNT_SLOT || cmd_q[15]) sch[si][i] <= shadow[i];
          end
        end
        if (!cmd_bad && sel == 2'b10) begin
          if (cmd_q[15]) begin
            if (rd_dir) win[0] <= prt[pi][0];
            else        prt[pi][0] <= shadow[0];
          end
          if (cmd_q[14]) begin
            if (rd_dir) win[1] <= prt[pi][1];
            else        prt[pi][1] <= shadow[1];
          end
        end
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_waddr == CMD_ADDR) host_rdata = {busy, cmd_q[30], err_q, cmd_q[28:0]};
    else if (win_hit)           host_rdata = win[widx[WIW-1:0]];
  end
endmodule

module cfg_table_access_chk #(
  parameter int LAT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ar_wr,
  input logic        start,
  input logic        done,
  input logic        cmd_bad,
  input logic        err_q,
  input logic [30:0] cmd_q
);
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 8'd1 : 8'd0;
  end

  p_go_span_r2: assert property (@(posedge clk) disable iff (!rst_n) 32'(run) <= LAT);
  p_go_rises_r2: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  p_go_falls_r2: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ar_wr && !done) |=> $stable(cmd_q));
  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n) (done && cmd_bad) |=> err_q);
  p_err_clr_r6: assert property (@(posedge clk) disable iff (!rst_n) (done && !cmd_bad) |=> !err_q);
endmodule

bind cfg_table_access cfg_table_access_chk #(.LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ar_wr(ar_wr), .start(start),
  .done(done), .cmd_bad(cmd_bad), .err_q(err_q), .cmd_q(cmd_q)
);

// File: tb/cfg_table_access_tb.sv
module cfg_table_access_tb;
  localparam int LAT = 3;
  localparam int WW  = 23;
  localparam logic [6:0] AR = 7'h7F;
  localparam logic [6:0] WB = 7'h40;

  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0;
  logic [6:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cfg_table_access #(.LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_rdata(host_rdata));

  typedef struct packed {
    logic [31:0] cmd;
    logic [31:0] seed;
    logic        exp_err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h8005_0000, 32'h1100_0000, 1'b0},  // R3 scheme 5 write, R4 no counter
    '{32'hC005_0000, 32'hEEEE_0000, 1'b0},  // R3 R4 read back 5
    '{32'h801F_8000, 32'h2200_0000, 1'b0},  // R3 R4 scheme 31 with counter
    '{32'hC01F_0000, 32'hDDDD_0000, 1'b0},  // R3 read 31
    '{32'h8005_8000, 32'h3300_0000, 1'b0},  // R4 counter now stored
    '{32'hC005_0000, 32'hCCCC_0000, 1'b0},  // R4 read back
    '{32'h8200_803F, 32'h4400_0000, 1'b0},  // R5 port 63 partition word only
    '{32'h8200_403F, 32'h5500_0000, 1'b0},  // R5 port 63 plan word only
    '{32'hC200_C03F, 32'hBBBB_0000, 1'b0},  // R5 read both words
    '{32'hC200_403F, 32'hAAAA_0000, 1'b0},  // R5 read plan word only
    '{32'h8020_0000, 32'h6600_0000, 1'b1},  // R6 scheme 32
    '{32'h8200_C040, 32'h7700_0000, 1'b1},  // R6 port 64
    '{32'h8100_0000, 32'h8800_0000, 1'b1},  // R6 select 01
    '{32'h8300_0000, 32'h9900_0000, 1'b1},  // R6 select 11
    '{32'hC000_0000, 32'h1234_0000, 1'b0},  // R6 scheme 0 untouched
    '{32'hC200_C000, 32'h5678_0000, 1'b0}   // R6 port 0 untouched
  };

  logic [31:0] sch_m [32][WW];
  logic [31:0] prt_m [64][2];
  logic [31:0] win_m [WW];

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    host_waddr = a; #1; d = host_rdata;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(AR, v);
    while (v[31] && n < 100) begin
      n++;
      @(negedge clk);
      rd(AR, v);
    end
  endtask

  task automatic model(input logic [31:0] c);
    logic [1:0] s = c[25:24];
    int si = int'(c[23:16]);
    int pi = int'(c[7:0]);
    bit bad = (s == 2'b00) ? (si >= 32) : (s == 2'b10) ? (pi >= 64) : 1'b1;
    if (bad) return;
    if (s == 2'b00) begin
      for (int i = 0; i < WW; i++)
        if (c[30]) win_m[i] = sch_m[si][i];
        else if (i != 16 || c[15]) sch_m[si][i] = win_m[i];
    end else begin
      for (int w = 0; w < 2; w++)
        if (c[15 - w]) begin
          if (c[30]) win_m[w] = prt_m[pi][w];
          else       prt_m[pi][w] = win_m[w];
        end
    end
  endtask

  initial begin
    logic [31:0] v;
    int n, bad;
    for (int e = 0; e < 32; e++) for (int i = 0; i < WW; i++) sch_m[e][i] = '0;
    for (int e = 0; e < 64; e++) begin prt_m[e][0] = '0; prt_m[e][1] = '0; end
    for (int i = 0; i < WW; i++) win_m[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(AR, v);      check("R1 command word", v, 32'h0);
    rd(WB, v);      check("R1 window word 0", v, 32'h0);
    rd(WB + 7'd22, v); check("R1 window word 22", v, 32'h0);

    for (int k = 0; k < NV; k++) begin
      for (int i = 0; i < WW; i++) begin
        win_m[i] = VECS[k].seed + 32'(i * 257);
        wr(WB + 7'(i), win_m[i]);
      end
      wr(AR, VECS[k].cmd);
      wait_idle(n);
      model(VECS[k].cmd);
      checks++;
      if (n != LAT) begin
        fails++;
        $display("FAIL R2 vector %0d: GO high %0d cycles expected %0d", k, n, LAT);
      end
      rd(AR, v);
      check($sformatf("R6 error bit vector %0d", k), {31'h0, v[29]}, {31'h0, VECS[k].exp_err});
      bad = 0;
      for (int i = 0; i < WW; i++) begin
        rd(WB + 7'(i), v);
        if (v !== win_m[i] && bad == 0) begin
          bad = 1;
          checks++; fails++;
          $display("FAIL R3/R4/R5 vector %0d word %0d: got %08h expected %08h", k, i, v, win_m[i]);
        end
      end
      if (bad == 0) checks++;
    end

    // R7: second command during GO is ignored
    wr(AR, 32'h8002_0000);
    wr(AR, 32'hC003_8000);
    wait_idle(n);
    model(32'h8002_0000);
    rd(AR, v);
    check("R7 command fields kept", v & 32'h7FFF_FFFF, 32'h0002_0000);

    // R8: window write during GO does not reach the entry
    win_m[0] = 32'hA5A5_0001;
    wr(WB, win_m[0]);
    wr(AR, 32'h8004_0000);
    wr(WB, 32'h5A5A_0002);
    rd(WB, v);
    check("R8 window takes new value", v, 32'h5A5A_0002);
    win_m[0] = 32'h5A5A_0002;
    wait_idle(n);
    sch_m[4][0] = 32'hA5A5_0001;
    for (int i = 1; i < WW; i++) sch_m[4][i] = (i == 16) ? 32'h0 : win_m[i];
    wr(AR, 32'hC004_0000);
    wait_idle(n);
    rd(WB, v);
    check("R8 entry holds staged value", v, 32'hA5A5_0001);
    rd(WB + 7'd16, v);
    check("R4 counter word not stored", v, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule